// File: doc/BRIEF.md
# Hashed Page Table Index Generator

This block sits in the translation path of a processor that keeps its page table as a hashed table of fixed-size entry groups. For each request it takes a 64-bit effective address, a virtual segment identifier, a one-bit segment-size code, a page-size shift and a table mask. From these it builds the virtual page number, which is kept in units of 4 KiB (the address shifted right by 12). It then mixes the page number into a 39-bit hash and derives two group indices: a primary index and a secondary (complement) index. The engine that searches the table uses them as group numbers. The byte offset of a group is its index times 128, because a group holds eight 16-byte entries.

The mixing depends on the segment size. For 256 MB segments the segment part of the page number is XORed with the in-segment page index. For 1 TB segments the segment part is first XORed with a copy of itself shifted left by 25, and the page index is folded in after that. A page shift below 12 is illegal. Such a request still flows through the pipeline, but it comes out flagged, with every index field at zero.

The block is a two-stage pipeline. It takes one request per cycle and holds its result while the consumer is not ready.

Top module: `hpt_index_gen`

## Requirements
- R1: With seg_1t = 0 (256 MB segment, segment shift 28), vpn = (vsid << 16) | ((ea >> 12) & 0xFFFF), taken to 64 bits.
- R2: With seg_1t = 1 (1 TB segment, segment shift 40), vpn = (vsid << 28) | ((ea >> 12) & 0xFFFFFFF), taken to 64 bits.
- R3: With seg_1t = 0, hash = (vpn >> 16) ^ ((vpn & 0xFFFF) >> (page_shift - 12)).
- R4: With seg_1t = 1 and s = vpn >> 28, hash = s ^ (s << 25) ^ ((vpn & 0xFFFFFFF) >> (page_shift - 12)), with the shifted copy confined to 64 bits.
- R5: The hash output is the low 39 bits of the mix, and higher bits are dropped even when a large identifier sets them.
- R6: grp_pri = hash & tab_mask and grp_sec = ~hash & tab_mask, using the mask given with the same request.
- R7: A page_shift below 12 sets shift_err on that result, and vpn, hash, grp_pri and grp_sec are all zero.
- R8: With out_ready held high, in_ready stays high, a request accepted on one rising edge is presented on out_valid after the second following rising edge, and back-to-back requests come out in order.
- R9: While out_valid is high and out_ready is low, every output holds its value and in_ready is low.
- R10: After reset, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request qualifier |
| in_ready | output | 1 | Request accepted when high together with in_valid |
| ea | input | 64 | Effective address |
| vsid | input | 37 | Virtual segment identifier |
| seg_1t | input | 1 | Segment size code: 0 = 256 MB, 1 = 1 TB |
| page_shift | input | 6 | Base-2 logarithm of the page size |
| tab_mask | input | 39 | Group index mask of the table |
| out_valid | output | 1 | Result qualifier |
| out_ready | input | 1 | Consumer can take the result |
| vpn | output | 64 | Virtual page number in 4 KiB units |
| hash | output | 39 | Page table hash |
| grp_pri | output | 39 | Primary group index |
| grp_sec | output | 39 | Secondary group index |
| shift_err | output | 1 | Page shift below 12 on this result |

## Verification
The bench drives random addresses and identifiers at page shifts 12, 16 and 24 in both segment sizes. A design that mixed up the 28 and 40 shift points would build wrong page numbers in the upper half of the page index, and one that left out the shift-by-25 fold would get 1 TB hashes wrong while its 256 MB hashes stayed correct. An all-ones identifier in 1 TB mode drives the fold past bit 38, so a hash that is not cut to 39 bits, or that is cut at the wrong place, shows up there. Page shifts 0 and 11 exercise the error path, which must zero every index rather than pass on a wrapped shift. Random consumer stalls check that a blocked result does not move and no request is lost, and an unstalled phase checks the exact two-edge latency.

// File: rtl/hpt_pkg.sv
package hpt_pkg;
   // Segment size code carried on seg_1t
   typedef enum logic {
      SEG_256M = 1'b0,
      SEG_1T   = 1'b1
   } seg_e;

   localparam int PAGE_LSB_D  = 12;  // VPN unit: 4 KiB
   localparam int SEG_SH_S_D  = 28;  // 256 MB segment
   localparam int SEG_SH_L_D  = 40;  // 1 TB segment
   localparam int FOLD_SH_D   = 25;  // self-fold of the 1 TB segment id
   localparam int GROUP_LG2_D = 7;   // 8 entries x 16 bytes
endpackage

// File: rtl/hpt_vpn_form.sv
module hpt_vpn_form #(
   parameter int EA_W     = 64,
   parameter int VSID_W   = 37,
   parameter int VPN_W    = 64,
   parameter int PAGE_LSB = hpt_pkg::PAGE_LSB_D,
   parameter int SEG_SH_S = hpt_pkg::SEG_SH_S_D,
   parameter int SEG_SH_L = hpt_pkg::SEG_SH_L_D
) (
   input  logic [EA_W-1:0]   ea,
   input  logic [VSID_W-1:0] vsid,
   input  hpt_pkg::seg_e     seg,
   output logic [VPN_W-1:0]  vpn
);
   localparam int KS = SEG_SH_S - PAGE_LSB;
   localparam int KL = SEG_SH_L - PAGE_LSB;
   localparam logic [VPN_W-1:0] MSK_S = (VPN_W'(1) << KS) - VPN_W'(1);
   localparam logic [VPN_W-1:0] MSK_L = (VPN_W'(1) << KL) - VPN_W'(1);

   logic [VPN_W-1:0] page_idx;
   logic [VPN_W-1:0] vsid_ext;
   logic [VPN_W-1:0] vpn_s;
   logic [VPN_W-1:0] vpn_l;

   assign page_idx = VPN_W'(ea >> PAGE_LSB);
   assign vsid_ext = VPN_W'(vsid);

   // R1, R2: segment id above the in-segment page index
   assign vpn_s = (vsid_ext << KS) | (page_idx & MSK_S);
   assign vpn_l = (vsid_ext << KL) | (page_idx & MSK_L);
   assign vpn   = (seg == hpt_pkg::SEG_1T) ? vpn_l : vpn_s;
endmodule

// File: rtl/hpt_hash_mix.sv
module hpt_hash_mix #(
   parameter int VPN_W    = 64,
   parameter int HASH_W   = 39,
   parameter int PS_W     = 6,
   parameter int PAGE_LSB = hpt_pkg::PAGE_LSB_D,
   parameter int SEG_SH_S = hpt_pkg::SEG_SH_S_D,
   parameter int SEG_SH_L = hpt_pkg::SEG_SH_L_D,
   parameter int FOLD_SH  = hpt_pkg::FOLD_SH_D
) (
   input  logic [VPN_W-1:0]  vpn,
   input  hpt_pkg::seg_e     seg,
   input  logic [PS_W-1:0]   pshift,
   output logic [HASH_W-1:0] hash,
   output logic              bad_shift
);
   localparam int KS = SEG_SH_S - PAGE_LSB;
   localparam int KL = SEG_SH_L - PAGE_LSB;
   localparam logic [VPN_W-1:0] MSK_S = (VPN_W'(1) << KS) - VPN_W'(1);
   localparam logic [VPN_W-1:0] MSK_L = (VPN_W'(1) << KL) - VPN_W'(1);

   logic [PS_W-1:0]  dsh;
   logic [VPN_W-1:0] mix_s;
   logic [VPN_W-1:0] seg_id_l;
   logic [VPN_W-1:0] fold_l;
   logic [VPN_W-1:0] mix_l;
   logic [VPN_W-1:0] mix;

   // R7: shifts below the VPN unit are illegal
   assign bad_shift = pshift < PS_W'(PAGE_LSB);
   assign dsh       = pshift - PS_W'(PAGE_LSB);

   // R3: small segment
   assign mix_s = (vpn >> KS) ^ ((vpn & MSK_S) >> dsh);

   // R4: large segment, id folded onto itself first
   assign seg_id_l = vpn >> KL;
   generate
      if (FOLD_SH > 0) begin : g_fold
         assign fold_l = seg_id_l << FOLD_SH;
      end else begin : g_nofold
         assign fold_l = '0;
      end
   endgenerate
   assign mix_l = seg_id_l ^ fold_l ^ ((vpn & MSK_L) >> dsh);

   assign mix  = (seg == hpt_pkg::SEG_1T) ? mix_l : mix_s;
   // R5: keep the low HASH_W bits only
   assign hash = HASH_W'(mix);
endmodule

// File: rtl/hpt_group_sel.sv
module hpt_group_sel #(
   parameter int HASH_W = 39
) (
   input  logic [HASH_W-1:0] hash,
   input  logic [HASH_W-1:0] tab_mask,
   output logic [HASH_W-1:0] grp_pri,
   output logic [HASH_W-1:0] grp_sec
);
   // R6: primary and complement group numbers
   assign grp_pri = hash & tab_mask;
   assign grp_sec = ~hash & tab_mask;
endmodule

// File: rtl/hpt_index_gen.sv
module hpt_index_gen #(
   parameter int EA_W     = 64,
   parameter int VSID_W   = 37,
   parameter int VPN_W    = 64,
   parameter int HASH_W   = 39,
   parameter int PS_W     = 6,
   parameter int PAGE_LSB = hpt_pkg::PAGE_LSB_D,
   parameter int SEG_SH_S = hpt_pkg::SEG_SH_S_D,
   parameter int SEG_SH_L = hpt_pkg::SEG_SH_L_D,
   parameter int FOLD_SH  = hpt_pkg::FOLD_SH_D
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [EA_W-1:0]   ea,
   input  logic [VSID_W-1:0] vsid,
   input  logic              seg_1t,
   input  logic [PS_W-1:0]   page_shift,
   input  logic [HASH_W-1:0] tab_mask,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [VPN_W-1:0]  vpn,
   output logic [HASH_W-1:0] hash,
   output logic [HASH_W-1:0] grp_pri,
   output logic [HASH_W-1:0] grp_sec,
   output logic              shift_err
);
   // Elaboration-time parameter checks
   generate
      if (SEG_SH_S <= PAGE_LSB || SEG_SH_L <= SEG_SH_S) begin : g_bad_seg
         $error("segment shifts must exceed the page unit and be ordered");
      end
      if (VPN_W < VSID_W || VPN_W < EA_W - PAGE_LSB) begin : g_bad_vpn
         $error("VPN_W too narrow for the identifier or address");
      end
      if (HASH_W > VPN_W) begin : g_bad_hash
         $error("HASH_W must not exceed VPN_W");
      end
      if ((1 << PS_W) <= SEG_SH_L) begin : g_bad_ps
         $error("PS_W cannot express a full segment shift");
      end
   endgenerate

   // Stage 1 registers
   logic               s1_v;
   logic [VPN_W-1:0]   s1_vpn;
   hpt_pkg::seg_e      s1_seg;
   logic [PS_W-1:0]    s1_ps;
   logic [HASH_W-1:0]  s1_mask;

   // Combinational pieces
   logic [VPN_W-1:0]   vpn_c;
   logic [HASH_W-1:0]  hash_c;
   logic               bad_c;
   logic [HASH_W-1:0]  pri_c;
   logic [HASH_W-1:0]  sec_c;
   logic               adv;

   // R8, R9: whole pipe advances when the output slot is free or drains
   assign adv      = !out_valid || out_ready;
   assign in_ready = adv;

   hpt_vpn_form #(
      .EA_W(EA_W), .VSID_W(VSID_W), .VPN_W(VPN_W),
      .PAGE_LSB(PAGE_LSB), .SEG_SH_S(SEG_SH_S), .SEG_SH_L(SEG_SH_L)
   ) u_vpn (
      .ea   (ea),
      .vsid (vsid),
      .seg  (hpt_pkg::seg_e'(seg_1t)),
      .vpn  (vpn_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_v    <= 1'b0;
         s1_vpn  <= '0;
         s1_seg  <= hpt_pkg::SEG_256M;
         s1_ps   <= '0;
         s1_mask <= '0;
      end else if (adv) begin
         s1_v    <= in_valid;
         s1_vpn  <= vpn_c;
         s1_seg  <= hpt_pkg::seg_e'(seg_1t);
         s1_ps   <= page_shift;
         s1_mask <= tab_mask;
      end
   end

   hpt_hash_mix #(
      .VPN_W(VPN_W), .HASH_W(HASH_W), .PS_W(PS_W), .PAGE_LSB(PAGE_LSB),
      .SEG_SH_S(SEG_SH_S), .SEG_SH_L(SEG_SH_L), .FOLD_SH(FOLD_SH)
   ) u_mix (
      .vpn       (s1_vpn),
      .seg       (s1_seg),
      .pshift    (s1_ps),
      .hash      (hash_c),
      .bad_shift (bad_c)
   );

   hpt_group_sel #(.HASH_W(HASH_W)) u_grp (
      .hash     (hash_c),
      .tab_mask (s1_mask),
      .grp_pri  (pri_c),
      .grp_sec  (sec_c)
   );

   // Stage 2 registers; R7 zeroes every index on an illegal shift
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         vpn       <= '0;
         hash      <= '0;
         grp_pri   <= '0;
         grp_sec   <= '0;
         shift_err <= 1'b0;
      end else if (adv) begin
         out_valid <= s1_v;
         shift_err <= bad_c;
         vpn       <= bad_c ? '0 : s1_vpn;
         hash      <= bad_c ? '0 : hash_c;
         grp_pri   <= bad_c ? '0 : pri_c;
         grp_sec   <= bad_c ? '0 : sec_c;
      end
   end
endmodule

// File: rtl/hpt_index_gen_chk.sv
module hpt_index_gen_chk #(
   parameter int VPN_W  = 64,
   parameter int HASH_W = 39
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_ready,
   input logic              out_valid,
   input logic              out_ready,
   input logic [VPN_W-1:0]  vpn,
   input logic [HASH_W-1:0] hash,
   input logic [HASH_W-1:0] grp_pri,
   input logic [HASH_W-1:0] grp_sec,
   input logic              shift_err
);
   assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(vpn) && $stable(hash)
         && $stable(grp_pri) && $stable(grp_sec) && $stable(shift_err)));

   assert_blocked_input_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |-> !in_ready);

   assert_err_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && shift_err) |-> (vpn == '0 && hash == '0
         && grp_pri == '0 && grp_sec == '0));

   assert_grp_disjoint_R6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ((grp_pri & grp_sec) == '0));

   assert_drain_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
      out_ready |-> in_ready);
endmodule

bind hpt_index_gen hpt_index_gen_chk #(.VPN_W(VPN_W), .HASH_W(HASH_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_ready  (in_ready),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .vpn       (vpn),
   .hash      (hash),
   .grp_pri   (grp_pri),
   .grp_sec   (grp_sec),
   .shift_err (shift_err)
);

// File: tb/hpt_index_gen_test.sv
module hpt_index_gen_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [63:0] ea = '0;
   logic [36:0] vsid = '0;
   logic        seg_1t = 1'b0;
   logic [5:0]  page_shift = 6'd12;
   logic [38:0] tab_mask = '0;
   logic        out_valid;
   logic        out_ready = 1'b1;
   logic [63:0] vpn;
   logic [38:0] hash, grp_pri, grp_sec;
   logic        shift_err;

   int errors = 0;
   int checks = 0;
   int cyc = 0;
   bit nostall = 1'b1;
   bit running = 1'b0;

   typedef struct {
      logic [63:0] vpn;
      logic [38:0] hash;
      logic [38:0] pri;
      logic [38:0] sec;
      logic        err;
      bit          seg;
      int          t;
      bit          timed;
      string       note;
   } exp_t;
   exp_t sb[$];

   always #10 clk = ~clk;   // 50 MHz
   always @(posedge clk) cyc <= cyc + 1;

   hpt_index_gen uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .ea(ea), .vsid(vsid), .seg_1t(seg_1t), .page_shift(page_shift),
      .tab_mask(tab_mask), .out_valid(out_valid), .out_ready(out_ready),
      .vpn(vpn), .hash(hash), .grp_pri(grp_pri), .grp_sec(grp_sec),
      .shift_err(shift_err)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
      end
   endtask

   // Reference model written from the requirements
   function automatic exp_t model(input logic [63:0] a, input logic [36:0] id,
                                  input bit s, input logic [5:0] ps,
                                  input logic [38:0] m);
      exp_t e;
      int k;
      logic [63:0] v, h, sid;
      k = s ? 28 : 16;
      v = ({27'd0, id} << k) | ((a >> 12) & ((64'd1 << k) - 64'd1));
      if (s) begin
         sid = v >> 28;
         h = sid ^ (sid << 25) ^ ((v & 64'hFFF_FFFF) >> (ps - 6'd12));
      end else begin
         h = (v >> 16) ^ ((v & 64'hFFFF) >> (ps - 6'd12));
      end
      e.seg = s;
      e.err = (ps < 6'd12);
      e.vpn  = e.err ? 64'd0 : v;
      e.hash = e.err ? 39'd0 : h[38:0];
      e.pri  = e.hash & m;
      e.sec  = e.err ? 39'd0 : (~h[38:0] & m);
      e.note = "";
      e.timed = 1'b0;
      e.t = 0;
      return e;
   endfunction

   // Driver: presents one request, pushes its expectation once accepted
   task automatic send(input logic [63:0] a, input logic [36:0] id, input bit s,
                       input logic [5:0] ps, input logic [38:0] m, input string note);
      exp_t e;
      @(posedge clk);
      #2;
      in_valid = 1'b1; ea = a; vsid = id; seg_1t = s; page_shift = ps; tab_mask = m;
      forever begin
         @(negedge clk);
         if (in_ready) break;
         @(posedge clk);
         #2;
      end
      e = model(a, id, s, ps, m);
      e.note = note;
      e.t = cyc;
      e.timed = nostall;
      sb.push_back(e);
   endtask

   task automatic idle();
      @(posedge clk);
      #2;
      in_valid = 1'b0;
   endtask

   // Consumer readiness
   always @(posedge clk) begin
      #1;
      out_ready = nostall ? 1'b1 : (($urandom % 3) != 0);
   end

   // Monitor
   logic        hold_prev = 1'b0;
   logic [63:0] h_vpn;
   logic [38:0] h_hash, h_pri, h_sec;
   always @(negedge clk) begin
      if (running) begin
         if (hold_prev) begin
            check(vpn == h_vpn && hash == h_hash && grp_pri == h_pri && grp_sec == h_sec
                  && out_valid, "R9", "held result", {25'd0, hash}, {25'd0, h_hash});
         end
         if (nostall) check(in_ready == 1'b1, "R8", "in_ready with consumer ready",
                            {63'd0, in_ready}, 64'd1);
         hold_prev = out_valid && !out_ready;
         h_vpn = vpn; h_hash = hash; h_pri = grp_pri; h_sec = grp_sec;
         if (out_valid && out_ready) begin
            if (sb.size() == 0) begin
               check(1'b0, "R8", "unexpected output", 64'd1, 64'd0);
            end else begin
               exp_t e;
               e = sb.pop_front();
               check(vpn == e.vpn, e.seg ? "R2" : "R1", "vpn", vpn, e.vpn);
               check(hash == e.hash, e.seg ? "R4" : "R3", {"hash ", e.note},
                     {25'd0, hash}, {25'd0, e.hash});
               check(grp_pri == e.pri && grp_sec == e.sec, "R6", "groups",
                     {grp_pri[31:0], grp_sec[31:0]}, {e.pri[31:0], e.sec[31:0]});
               check(shift_err == e.err, "R7", "shift_err",
                     {63'd0, shift_err}, {63'd0, e.err});
               if (e.timed)
                  check(cyc == e.t + 2, "R8", "latency", 64'(cyc), 64'(e.t + 2));
            end
         end
      end
   end

   // Watchdog
   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
   end

   logic [5:0] shifts [3] = '{6'd12, 6'd16, 6'd24};

   initial begin
      repeat (3) @(posedge clk);
      #5;
      check(out_valid == 1'b0 && in_ready == 1'b1, "R10", "reset state",
            {62'd0, out_valid, in_ready}, 64'd1);
      rst_n = 1'b1;
      running = 1'b1;

      // Directed, unstalled: latency and fixed values
      send(64'h0000_0000_1234_5000, 37'h1, 1'b0, 6'd12, 39'hFF, "R3 small");
      send(64'h0000_00AB_CDEF_0000, 37'h15, 1'b1, 6'd16, 39'h7FF, "R4 large");
      send(64'hFFFF_FFFF_FFFF_FFFF, 37'h1F_FFFF_FFFF, 1'b1, 6'd12, 39'h7F_FFFF_FFFF,
           "R5 truncation");
      send(64'hFFFF_FFFF_FFFF_FFFF, 37'h1F_FFFF_FFFF, 1'b0, 6'd24, 39'h7F_FFFF_FFFF,
           "R5 small wide");
      send(64'h0000_0123_4567_8000, 37'h9, 1'b0, 6'd11, 39'hFFF, "R7 shift 11");
      send(64'h0000_0123_4567_8000, 37'h9, 1'b1, 6'd0, 39'hFFF, "R7 shift 0");
      idle();
      repeat (4) @(posedge clk);

      // Random back-to-back, unstalled
      for (int i = 0; i < 60; i++) begin
         send({$urandom, $urandom}, {5'($urandom), $urandom}, 1'($urandom),
              shifts[i % 3], {7'($urandom), $urandom}, "random");
      end
      idle();
      repeat (4) @(posedge clk);

      // Random with consumer stalls
      nostall = 1'b0;
      for (int i = 0; i < 200; i++) begin
         send({$urandom, $urandom}, {5'($urandom), $urandom}, 1'($urandom),
              (i % 17 == 0) ? 6'($urandom % 12) : shifts[i % 3],
              {7'($urandom), $urandom}, "stalled");
      end
      idle();
      nostall = 1'b1;
      repeat (10) @(posedge clk);
      check(sb.size() == 0, "R8", "all results delivered", 64'(sb.size()), 64'd0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule